// File: doc/BRIEF.md
# Two-Pin Link Escape and Reset Detector

This block sits on a two-wire debug link made of a test clock and one bidirectional mode/data wire. Both wires reach it as levels that the fast system clock samples. Normal data on the mode/data wire only changes while the test clock is low. When the wire toggles while the test clock is high, the toggles are out-of-band control. The block counts these toggles over each high phase of the test clock. When the test clock falls, it sorts the burst into one of three results: an escape (two or three toggles), a link reset (six or more toggles), or nothing.

The block also controls the device's output enable for the shared wire. The enable can only be active while the test clock is low. It also holds the link's data-sampling edge choice (rising or falling edge of the test clock). A link reset puts that choice back to the rising edge.

Top module: `tpe_escape_det`

## Requirements
- R1: `tmsc_oe` equals `drive_req` as registered on the previous `clk` edge, forced low in every cycle where `tck` is high; it is never high while `tck` is high.
- R2: A toggle of `tmsc` is counted only when `tck` was sampled high on both the previous and the current `clk` edge. The count clears on the `clk` edge that first samples `tck` high. Toggles sampled together with the rising or the falling sample of `tck` are not counted.
- R3: On the `clk` edge that first samples `tck` low after a high phase, a count of 2 or 3 raises `esc_pulse` for exactly one cycle. `esc_long` is 1 with it for a count of 3 and 0 for a count of 2.
- R4: On that same falling sample, a count of six or more raises `lrst_pulse` for one cycle. The counter saturates, so a burst of any length from six upwards (for example 20) still gives a link reset.
- R5: Counts of 0, 1, 4 and 5 produce neither pulse.
- R6: `esc_pulse` and `lrst_pulse` are never high together, each lasts a single cycle, and neither rises at any moment other than just after a falling sample of `tck`. `esc_long` is 0 whenever `esc_pulse` is 0.
- R7: `smp_fall` (0 = sample on the rising edge of the test clock, 1 = sample on the falling edge) loads `edge_val` when `edge_wr` is high. A link reset clears it to 0, and the clear takes priority over a write in the same cycle.
- R8: While `rst` is high, and after its release, `esc_pulse`, `esc_long`, `lrst_pulse`, `smp_fall` and `tmsc_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both link wires |
| rst | input | 1 | Synchronous active-high reset |
| tck | input | 1 | Sampled level of the link test clock |
| tmsc | input | 1 | Sampled level of the bidirectional mode/data wire |
| drive_req | input | 1 | Device wants to drive the mode/data wire |
| edge_wr | input | 1 | Load strobe for the sample-edge choice |
| edge_val | input | 1 | New sample-edge choice (1 = falling edge) |
| tmsc_oe | output | 1 | Output enable for the mode/data wire driver |
| esc_pulse | output | 1 | One-cycle escape indication |
| esc_long | output | 1 | With `esc_pulse`: 1 for a three-toggle escape |
| lrst_pulse | output | 1 | One-cycle link-reset indication |
| smp_fall | output | 1 | Current sample-edge choice |

## Verification
A counter that clears at the wrong time, or misses toggles, gives the wrong kind of event at the very next falling sample of the test clock. The ports therefore show it within one high phase: an escape where none should be, a two-toggle escape reported as three, or a missing link reset. A counter that wraps instead of saturating shows up only on long bursts, so bursts well past six toggles are driven. A stale sample-edge register shows on `smp_fall` in the cycle after a link reset. An enable not gated by the test clock shows on `tmsc_oe` in the very cycle the clock rises.

// File: rtl/tpe_pkg.sv
package tpe_pkg;
  typedef struct packed {
    logic esc;
    logic esc_long;
    logic lrst;
  } tpe_event_t;
endpackage

// File: rtl/tpe_sync.sv
module tpe_sync (
  input  logic clk,
  input  logic rst,
  input  logic tck,
  input  logic tmsc,
  output logic tck_rise,
  output logic tck_fall,
  output logic hi_toggle
);
  logic tck_q;
  logic tmsc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tck_q  <= 1'b0;
      tmsc_q <= 1'b0;
    end else begin
      tck_q  <= tck;
      tmsc_q <= tmsc;
    end
  end

  assign tck_rise  = tck & ~tck_q;
  assign tck_fall  = ~tck & tck_q;
  assign hi_toggle = tck & tck_q & (tmsc ^ tmsc_q);
endmodule

// File: rtl/tpe_counter.sv
module tpe_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc && cnt != CntMax) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tpe_classify.sv
module tpe_classify
  import tpe_pkg::*;
#(
  parameter int CNT_W      = 3,
  parameter int ESC_MIN    = 2,
  parameter int ESC_MAX    = 3,
  parameter int LRST_EDGES = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             judge,
  input  logic [CNT_W-1:0] cnt,
  output tpe_event_t       evt
);
  localparam logic [CNT_W-1:0] EscLo  = CNT_W'(ESC_MIN);
  localparam logic [CNT_W-1:0] EscHi  = CNT_W'(ESC_MAX);
  localparam logic [CNT_W-1:0] LrstLo = CNT_W'(LRST_EDGES);

  tpe_event_t nxt;

  always_comb begin
    nxt = '0;
    if (judge) begin
      nxt.esc      = (cnt >= EscLo) && (cnt <= EscHi);
      nxt.esc_long = (cnt == EscHi) && (EscHi != EscLo);
      nxt.lrst     = (cnt >= LrstLo);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) evt <= '0;
    else     evt <= nxt;
  end
endmodule

// File: rtl/tpe_edge_sel.sv
module tpe_edge_sel (
  input  logic clk,
  input  logic rst,
  input  logic link_rst,
  input  logic wr,
  input  logic val,
  output logic sel_fall
);
  always_ff @(posedge clk) begin
    if (rst || link_rst) sel_fall <= 1'b0;
    else if (wr)         sel_fall <= val;
  end
endmodule

// File: rtl/tpe_escape_det.sv
module tpe_escape_det
  import tpe_pkg::*;
#(
  parameter int ESC_MIN    = 2,
  parameter int ESC_MAX    = 3,
  parameter int LRST_EDGES = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tck,
  input  logic tmsc,
  input  logic drive_req,
  input  logic edge_wr,
  input  logic edge_val,
  output logic tmsc_oe,
  output logic esc_pulse,
  output logic esc_long,
  output logic lrst_pulse,
  output logic smp_fall
);
  localparam int CNT_W = $clog2(LRST_EDGES + 1);

  logic             tck_rise;
  logic             tck_fall;
  logic             hi_toggle;
  logic [CNT_W-1:0] cnt;
  tpe_event_t       evt;
  logic             oe_arm_q;
  logic             lrst_now;

  tpe_sync u_sync (
    .clk       (clk),
    .rst       (rst),
    .tck       (tck),
    .tmsc      (tmsc),
    .tck_rise  (tck_rise),
    .tck_fall  (tck_fall),
    .hi_toggle (hi_toggle)
  );

  tpe_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (tck_rise),
    .inc (hi_toggle),
    .cnt (cnt)
  );

  tpe_classify #(
    .CNT_W      (CNT_W),
    .ESC_MIN    (ESC_MIN),
    .ESC_MAX    (ESC_MAX),
    .LRST_EDGES (LRST_EDGES)
  ) u_cls (
    .clk   (clk),
    .rst   (rst),
    .judge (tck_fall),
    .cnt   (cnt),
    .evt   (evt)
  );

  // Link reset decided this cycle: clears the edge choice on the same clk edge
  // that registers lrst_pulse.
  assign lrst_now = tck_fall && (cnt >= CNT_W'(LRST_EDGES));

  tpe_edge_sel u_sel (
    .clk      (clk),
    .rst      (rst),
    .link_rst (lrst_now),
    .wr       (edge_wr),
    .val      (edge_val),
    .sel_fall (smp_fall)
  );

  always_ff @(posedge clk) begin
    if (rst) oe_arm_q <= 1'b0;
    else     oe_arm_q <= drive_req;
  end

  // One gate after the register keeps the driver off for the whole high phase.
  assign tmsc_oe    = oe_arm_q & ~tck;
  assign esc_pulse  = evt.esc;
  assign esc_long   = evt.esc_long;
  assign lrst_pulse = evt.lrst;
endmodule

// File: rtl/tpe_escape_det_chk.sv
module tpe_escape_det_chk (
  input logic clk,
  input logic rst,
  input logic tck,
  input logic tmsc_oe,
  input logic esc_pulse,
  input logic esc_long,
  input logic lrst_pulse,
  input logic smp_fall
);
  // R1
  oe_off_high_chk: assert property (@(posedge clk) disable iff (rst)
    tck |-> !tmsc_oe);

  // R6
  evt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(esc_pulse && lrst_pulse));

  // R6
  esc_single_chk: assert property (@(posedge clk) disable iff (rst)
    esc_pulse |=> !esc_pulse);

  // R6
  lrst_single_chk: assert property (@(posedge clk) disable iff (rst)
    lrst_pulse |=> !lrst_pulse);

  // R6
  evt_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (esc_pulse || lrst_pulse) |-> (!$past(tck) && $past(tck, 2)));

  // R3
  long_with_esc_chk: assert property (@(posedge clk) disable iff (rst)
    esc_long |-> esc_pulse);

  // R7
  lrst_clears_sel_chk: assert property (@(posedge clk) disable iff (rst)
    lrst_pulse |-> !smp_fall);
endmodule

bind tpe_escape_det tpe_escape_det_chk u_tpe_chk (
  .clk        (clk),
  .rst        (rst),
  .tck        (tck),
  .tmsc_oe    (tmsc_oe),
  .esc_pulse  (esc_pulse),
  .esc_long   (esc_long),
  .lrst_pulse (lrst_pulse),
  .smp_fall   (smp_fall)
);

// File: tb/tpe_escape_det_bench.sv
`timescale 1ns/1ps
module tpe_escape_det_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tck = 1'b0;
  logic tmsc = 1'b0;
  logic drive_req = 1'b0;
  logic edge_wr = 1'b0;
  logic edge_val = 1'b0;
  logic tmsc_oe, esc_pulse, esc_long, lrst_pulse, smp_fall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [2:0] exp_q[$];   // {esc, esc_long, lrst}
  string      tag_q[$];

  always #4 clk = ~clk;

  tpe_escape_det u_tpe_escape_det (
    .clk(clk), .rst(rst), .tck(tck), .tmsc(tmsc), .drive_req(drive_req),
    .edge_wr(edge_wr), .edge_val(edge_val), .tmsc_oe(tmsc_oe),
    .esc_pulse(esc_pulse), .esc_long(esc_long), .lrst_pulse(lrst_pulse),
    .smp_fall(smp_fall)
  );

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Driver: one high phase of tck with n counted toggles of tmsc.
  // extra=1 also toggles on the rise and fall samples (must not count, R2).
  task automatic burst(input int n, input bit extra, input bit wr_at_fall,
                       input string req);
    logic [2:0] e;
    e[2] = (n == 2 || n == 3);
    e[1] = (n == 3);
    e[0] = (n >= 6);
    exp_q.push_back(e);
    tag_q.push_back(req);
    @(negedge clk);
    tck = 1'b1;
    if (extra) tmsc = ~tmsc;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tmsc = ~tmsc;
    end
    @(negedge clk);
    tck = 1'b0;
    if (extra) tmsc = ~tmsc;
    if (wr_at_fall) begin
      edge_wr  = 1'b1;
      edge_val = 1'b1;
    end
    @(negedge clk);
    edge_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Monitor: bench's own view of tck at each posedge, compare after a fall.
  logic tck_s0 = 1'b0, tck_s1 = 1'b0;
  always @(posedge clk) begin
    tck_s1 <= tck_s0;
    tck_s0 <= tck;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (tck_s1 && !tck_s0) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R6: fall with no expected item");
        end else begin
          logic [2:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          checks++;
          if ({esc_pulse, esc_long, lrst_pulse} !== e) begin
            fails++;
            $display("FAIL %s: actual esc/long/lrst %b expected %b", t,
                     {esc_pulse, esc_long, lrst_pulse}, e);
          end
        end
      end else if (esc_pulse || lrst_pulse || esc_long) begin
        checks++; fails++;
        $display("FAIL R6: pulse outside fall cycle actual %b expected 000",
                 {esc_pulse, esc_long, lrst_pulse});
      end
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check1("R8 esc", esc_pulse, 1'b0);
    check1("R8 lrst", lrst_pulse, 1'b0);
    check1("R8 sel", smp_fall, 1'b0);
    check1("R8 oe", tmsc_oe, 1'b0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check1("R8 sel after release", smp_fall, 1'b0);

    // R1 output enable
    drive_req = 1'b1;
    @(negedge clk);
    check1("R1 oe low phase", tmsc_oe, 1'b1);
    tck = 1'b1;
    #1 check1("R1 oe off at tck high", tmsc_oe, 1'b0);
    @(negedge clk);
    check1("R1 oe off during high", tmsc_oe, 1'b0);
    exp_q.push_back(3'b000); tag_q.push_back("R5 zero toggles");
    tck = 1'b0;
    @(negedge clk);
    check1("R1 oe back after fall", tmsc_oe, 1'b1);
    drive_req = 1'b0;
    @(negedge clk);
    check1("R1 oe follows request", tmsc_oe, 1'b0);
    repeat (2) @(negedge clk);

    // R3 / R5 / R4 classification
    burst(0,  1'b0, 1'b0, "R5 count 0");
    burst(1,  1'b0, 1'b0, "R5 count 1");
    burst(2,  1'b0, 1'b0, "R3 count 2");
    burst(3,  1'b0, 1'b0, "R3 count 3");
    burst(4,  1'b0, 1'b0, "R5 count 4");
    burst(5,  1'b0, 1'b0, "R5 count 5");
    burst(6,  1'b0, 1'b0, "R4 count 6");
    burst(20, 1'b0, 1'b0, "R4 saturate 20");
    burst(8,  1'b0, 1'b0, "R4 count 8");
    // R2: toggles on rise/fall samples are not counted
    burst(1,  1'b1, 1'b0, "R2 edges at rise/fall ignored (1)");
    burst(3,  1'b1, 1'b0, "R2 edges at rise/fall ignored (3)");
    burst(5,  1'b1, 1'b0, "R2 edges at rise/fall ignored (5)");
    // R2: counter cleared between bursts
    burst(1,  1'b0, 1'b0, "R2 clear before burst a");
    burst(1,  1'b0, 1'b0, "R2 clear before burst b");

    // R7 sample-edge choice
    @(negedge clk);
    edge_wr = 1'b1; edge_val = 1'b1;
    @(negedge clk);
    edge_wr = 1'b0;
    check1("R7 write falling", smp_fall, 1'b1);
    burst(2, 1'b0, 1'b0, "R7 escape keeps choice");
    check1("R7 kept after escape", smp_fall, 1'b1);
    burst(7, 1'b0, 1'b0, "R7 link reset");
    check1("R7 cleared by link reset", smp_fall, 1'b0);
    @(negedge clk);
    edge_wr = 1'b1; edge_val = 1'b1;
    @(negedge clk);
    edge_wr = 1'b0;
    check1("R7 rewrite", smp_fall, 1'b1);
    edge_wr = 1'b1; edge_val = 1'b0;
    @(negedge clk);
    edge_wr = 1'b0;
    check1("R7 write rising", smp_fall, 1'b0);
    burst(6, 1'b0, 1'b1, "R7 reset beats write");
    check1("R7 reset priority", smp_fall, 1'b0);
    burst(2, 1'b0, 1'b1, "R7 write at escape");
    check1("R7 write with escape", smp_fall, 1'b1);

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6: actual %0d pending events expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule